// File: doc/BRIEF.md
# Machine-Cycle State Sequencer with Wait Insertion

This block steps a processor bus interface through the timing states of a single machine cycle. Each cycle opens with state T1, moves to T2, and then either goes straight to T3 or stretches through any number of whole-clock wait states (TW) until the memory or I/O side reports that it is ready. After T3 the cycle either ends or continues through T4 and, if requested, T5. Then the sequencer returns to T1 for the next cycle.

The instruction decoder supplies the number of states the cycle needs (3, 4 or 5). The sequencer latches that number in T1 and keeps it for the rest of the cycle. The outputs are the current state code, a start-of-cycle marker, a wait acknowledge, an enable that keeps the address lines driven, and a pulse that flags the final state of the cycle. Other blocks use these outputs to time bus strobes and to advance the decoder.

Top module: `mcseq_top`

## Requirements
- R1: While reset is high, and in the first cycle after reset, the state code is T1, `syncOut` is 1 and `waitAck` is 0. The state codes are T1=0, T2=1, TW=2, T3=3, T4=4, T5=5.
- R2: `syncOut` is 1 exactly when the state is T1. T1 always lasts one clock and is followed by T2.
- R3: When `ready` is 1 while the state is T2 or TW, the next state is T3.
- R4: When `ready` is 0 while the state is T2 or TW, the next state is TW. `waitAck` is 1 exactly while the state is TW, and a wait may last any number of clocks.
- R5: `addrEn` is 1 in T1, T2, TW and T3, and 0 in T4 and T5.
- R6: After T3 the sequencer goes to T1 when the latched count is 3 and to T4 otherwise. After T4 it goes to T1 when the count is 4 and to T5 when it is 5. After T5 it always goes to T1.
- R7: `cycleEnd` is 1 for exactly one clock per machine cycle, during the cycle's final state (T3, T4 or T5), and the state that follows is T1.
- R8: `stateCount` is captured only in T1. Changing it during any later state of the cycle has no effect on that cycle's length.
- R9: A captured `stateCount` below 3 acts as 3, and a value above 5 acts as 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state lasts one period |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | 1 | High when the addressed device can complete the transfer |
| stateCount | input | CNT_W | States requested for this cycle (3, 4 or 5) |
| stateCode | output | 3 | Current state: T1=0, T2=1, TW=2, T3=3, T4=4, T5=5 |
| syncOut | output | 1 | High during T1 |
| waitAck | output | 1 | High during TW |
| addrEn | output | 1 | Address drivers enabled, T1 through T3 |
| cycleEnd | output | 1 | High in the last state of the machine cycle |

## Verification
The bench builds the block with its default `CNT_W` of 3. This width lets the bench drive out-of-range counts such as 1 and 7 as well as 3, 4 and 5, so both clamp directions are covered. The stimulus includes back-to-back cycles of every length, waits of zero, one, three and forty clocks, and counts that change after T1 to expose any capture outside T1.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  typedef enum logic [2:0] {
    ST_T1 = 3'd0,
    ST_T2 = 3'd1,
    ST_TW = 3'd2,
    ST_T3 = 3'd3,
    ST_T4 = 3'd4,
    ST_T5 = 3'd5
  } tState;

  typedef struct packed {
    logic captureCnt;
  } tStrobe;
endpackage

// File: rtl/mcseq_count.sv
module mcseq_count #(
  parameter int CNT_W = 3,
  parameter int MIN_STATES = 3,
  parameter int MAX_STATES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  mcseq_pkg::tStrobe strobe,
  input  logic [CNT_W-1:0] reqCount,
  output logic             stopAtT3,
  output logic             stopAtT4
);
  localparam logic [CNT_W-1:0] LoLim = CNT_W'(MIN_STATES);
  localparam logic [CNT_W-1:0] HiLim = CNT_W'(MAX_STATES);
  localparam logic [CNT_W-1:0] MidLim = CNT_W'(MIN_STATES + 1);

  logic [CNT_W-1:0] clampCnt;
  logic [CNT_W-1:0] heldCnt;

  always_comb begin
    if (reqCount < LoLim)      clampCnt = LoLim;
    else if (reqCount > HiLim) clampCnt = HiLim;
    else                       clampCnt = reqCount;
  end

  always_ff @(posedge clk) begin
    if (rst)                    heldCnt <= LoLim;
    else if (strobe.captureCnt) heldCnt <= clampCnt;
  end

  assign stopAtT3 = (heldCnt == LoLim);
  assign stopAtT4 = (heldCnt == MidLim);

  // R8: the latched length only moves on a capture strobe
  p_hold_len_r8: assert property (@(posedge clk) disable iff (rst)
    !strobe.captureCnt |=> $stable(heldCnt));
  // R9: the latched length stays inside the legal range
  p_len_range_r9: assert property (@(posedge clk) disable iff (rst)
    strobe.captureCnt |=> (heldCnt >= LoLim && heldCnt <= HiLim));
endmodule

// File: rtl/mcseq_ctrl.sv
module mcseq_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              stopAtT3,
  input  logic              stopAtT4,
  output mcseq_pkg::tStrobe strobe,
  output mcseq_pkg::tState  curState,
  output logic              syncOut,
  output logic              waitAck,
  output logic              addrEn,
  output logic              cycleEnd
);
  import mcseq_pkg::*;

  tState nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_T1: nextState = ST_T2;
      ST_T2: nextState = ready ? ST_T3 : ST_TW;
      ST_TW: nextState = ready ? ST_T3 : ST_TW;
      ST_T3: nextState = stopAtT3 ? ST_T1 : ST_T4;
      ST_T4: nextState = stopAtT4 ? ST_T1 : ST_T5;
      ST_T5: nextState = ST_T1;
      default: nextState = ST_T1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_T1;
    else     curState <= nextState;
  end

  assign strobe.captureCnt = (curState == ST_T1);
  assign syncOut  = (curState == ST_T1);
  assign waitAck  = (curState == ST_TW);
  assign addrEn   = (curState == ST_T1) || (curState == ST_T2) ||
                    (curState == ST_TW) || (curState == ST_T3);
  assign cycleEnd = ((curState == ST_T3) && stopAtT3) ||
                    ((curState == ST_T4) && stopAtT4) ||
                    (curState == ST_T5);

  // R2: T1 lasts a single clock and leads to T2
  p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (rst)
    syncOut |=> (curState == ST_T2));
  // R3: ready seen in T2 or TW leads to T3
  p_ready_exit_r3: assert property (@(posedge clk) disable iff (rst)
    ((curState == ST_T2 || curState == ST_TW) && ready) |=> (curState == ST_T3));
  // R4: not ready in T2 or TW holds the sequencer in TW with the acknowledge high
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((curState == ST_T2 || curState == ST_TW) && !ready) |=> waitAck);
  // R7: the end marker is always followed by a fresh T1
  p_end_restart_r7: assert property (@(posedge clk) disable iff (rst)
    cycleEnd |=> syncOut);
  // R6: T4 is only ever entered from T3
  p_t4_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_T4) |-> ($past(curState) == ST_T3));
  // R1: state register holds a legal code
  p_legal_state_r1: assert property (@(posedge clk) disable iff (rst)
    curState inside {ST_T1, ST_T2, ST_TW, ST_T3, ST_T4, ST_T5});
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic [CNT_W-1:0] stateCount,
  output logic [2:0]       stateCode,
  output logic             syncOut,
  output logic             waitAck,
  output logic             addrEn,
  output logic             cycleEnd
);
  import mcseq_pkg::*;

  tStrobe strobe;
  tState  curState;
  logic   stopAtT3;
  logic   stopAtT4;

  mcseq_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .reqCount (stateCount),
    .stopAtT3 (stopAtT3),
    .stopAtT4 (stopAtT4)
  );

  mcseq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .stopAtT3 (stopAtT3),
    .stopAtT4 (stopAtT4),
    .strobe   (strobe),
    .curState (curState),
    .syncOut  (syncOut),
    .waitAck  (waitAck),
    .addrEn   (addrEn),
    .cycleEnd (cycleEnd)
  );

  assign stateCode = curState;
endmodule

// File: tb/sim_mcseq_top.sv
`timescale 1ns/1ps
module sim_mcseq_top;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ready = 1'b1;
  logic [CNT_W-1:0] stateCount = 3'd3;
  logic [2:0] stateCode;
  logic syncOut, waitAck, addrEn, cycleEnd;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic sy;
    logic wt;
    logic ae;
    logic ec;
    string tag;
  } tExp;

  tExp expQ[$];

  always #4 clk = ~clk;

  mcseq_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .ready(ready), .stateCount(stateCount),
    .stateCode(stateCode), .syncOut(syncOut), .waitAck(waitAck),
    .addrEn(addrEn), .cycleEnd(cycleEnd)
  );

  task automatic check1(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // push the expectation of the clock now running, set inputs for its decision, move on
  task automatic step(input logic [2:0] st, input logic ec, input logic rdy,
                      input logic [CNT_W-1:0] cnt, input string tag);
    tExp e;
    e.st = st;
    e.sy = (st == 3'd0);
    e.wt = (st == 3'd2);
    e.ae = (st <= 3'd3);
    e.ec = ec;
    e.tag = tag;
    expQ.push_back(e);
    ready = rdy;
    stateCount = cnt;
    @(negedge clk);
  endtask

  task automatic machineCycle(input logic [CNT_W-1:0] req, input int waits,
                              input logic [CNT_W-1:0] later, input string tag);
    int eff;
    eff = (req < 3) ? 3 : ((req > 5) ? 5 : int'(req));
    step(3'd0, 1'b0, 1'b1, req, "R2");
    step(3'd1, 1'b0, (waits == 0), later, "R3");
    for (int i = 0; i < waits; i++)
      step(3'd2, 1'b0, (i == waits - 1), later, "R4");
    step(3'd3, (eff == 3), 1'b0, later, tag);
    if (eff >= 4) step(3'd4, (eff == 4), 1'b1, later, tag);
    if (eff == 5) step(3'd5, 1'b1, 1'b0, later, tag);
  endtask

  // monitor: compare outputs mid-cycle against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        tExp e;
        e = expQ.pop_front();
        check1(e.tag, "stateCode", stateCode, e.st);
        check1("R2", "syncOut", {2'b0, syncOut}, {2'b0, e.sy});
        check1("R4", "waitAck", {2'b0, waitAck}, {2'b0, e.wt});
        check1("R5", "addrEn", {2'b0, addrEn}, {2'b0, e.ae});
        check1("R7", "cycleEnd", {2'b0, cycleEnd}, {2'b0, e.ec});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1", "stateCode in reset", stateCode, 3'd0);
    check1("R1", "waitAck in reset", {2'b0, waitAck}, 3'd0);
    check1("R1", "syncOut in reset", {2'b0, syncOut}, 3'd1);
    rst = 1'b0;
    machineCycle(3'd3, 0, 3'd3, "R6");
    machineCycle(3'd4, 1, 3'd4, "R6");
    machineCycle(3'd5, 3, 3'd5, "R6");
    machineCycle(3'd3, 0, 3'd5, "R8");
    machineCycle(3'd5, 2, 3'd3, "R8");
    machineCycle(3'd4, 0, 3'd7, "R8");
    machineCycle(3'd1, 0, 3'd1, "R9");
    machineCycle(3'd7, 1, 3'd7, "R9");
    machineCycle(3'd0, 0, 3'd6, "R9");
    machineCycle(3'd4, 40, 3'd4, "R4");
    machineCycle(3'd5, 0, 3'd5, "R6");
    machineCycle(3'd3, 0, 3'd3, "R6");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule